// File: doc/BRIEF.md
# Masked-Write Multichannel SAR Converter Controller

This block is the digital side of a successive-approximation converter. Software reaches it through a simple 32-bit register port. Every writable control register takes a per-bit write enable in the upper half-word of the write data. A write therefore changes only the bits it names, and software never needs a read-modify-write. Software sets a power-up delay, a sample window and the end-of-conversion interrupt enable. It then writes a start request that carries the single-conversion flag and a channel number.

After an accepted start, the controller keeps the analog front end powered for the power-up delay and holds the sample switch for the sample window. It then runs the binary search, deciding one bit per clock from the most significant bit down. The trial code goes out on `dac_code`, and the comparator answer comes back on `cmp_in`. The finished code lands in the result register of the selected channel only. A pending flag is raised, and software clears it by writing a 1.

Top module: `adc_mask_ctrl`

## Requirements
- R1: For the masked registers (conversion control 0x000, power-up delay 0x004, sample window 0x00C, interrupt enable 0x104), a write updates data bit n (n < 16) only when bit n+16 of the same write is 1. Every other bit keeps its value.
- R2: After reset, 0x004 reads 0x0020 and 0x00C reads 0x000C. The interrupt enable, the pending flag, the busy bit, every result register and `irq` all read 0.
- R3: A start (bit 4 of 0x000) is accepted one clock after it is written, provided the single-conversion bit (bit 5) is 1 and the channel field (bits 3:0) is below NCH. Once the start is accepted or rejected, bit 4 reads back as 0.
- R4: An accepted conversion keeps `afe_pwr` and status bit 0 (0x10C) high for P+S+RES cycles, and `sample_hold` high for S of those cycles. P and S are the programmed delay and window, and a programmed 0 counts as 1.
- R5: The search tests one bit per clock, MSB first. `cmp_in`=1 means the input is at or above `dac_code`. With an ideal comparator the stored result equals the input code, including 0x000 and 0xFFF.
- R6: Channel n's result reads at 0x120 + 4*n in bits [RES-1:0]. A completed conversion changes only the channel that was latched at the start.
- R7: A start with a channel number of NCH or above does not convert, does not raise the pending flag and leaves all results unchanged.
- R8: A start written with the single-conversion bit at 0 is ignored.
- R9: The pending flag (0x110 bit 0) sets when a conversion completes. `irq` equals the pending flag AND the enable (0x104 bit 0).
- R10: Writing 1 to bit 0 of 0x110 clears the pending flag. Writing 0 leaves it set.
- R11: A start written while a conversion is running has no effect, and no second conversion follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data, with mask in bits [31:16] |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cmp_in | input | 1 | Comparator result for the current trial code |
| dac_code | output | RES | Trial code for the converter DAC |
| afe_pwr | output | 1 | Analog front end power / busy |
| sample_hold | output | 1 | Sample switch closed |
| irq | output | 1 | End-of-conversion interrupt |

## Verification
The bound checker checks the following on every cycle:
- the search index steps down by exactly one per clock;
- the result bank holds still except on a completion cycle;
- completion always sets the pending flag, and the write-one clear always drops it;
- a conversion begins only after a legal start;
- an accepted start reads back cleared;
- `sample_hold` never rises outside a conversion.

Only the directed scenarios can show the rest:
- the exact conversion length for several programmed timings, including zero;
- the masked merge values;
- the numeric results for edge codes;
- that a rejected or mid-conversion start leaves every observable register as it was.

// File: rtl/adc_mask_pkg.sv
package adc_mask_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_CONV = 12'h000;
  localparam logic [ADDR_W-1:0] A_PDLY = 12'h004;
  localparam logic [ADDR_W-1:0] A_SWIN = 12'h00C;
  localparam logic [ADDR_W-1:0] A_IEN  = 12'h104;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h10C;
  localparam logic [ADDR_W-1:0] A_IPND = 12'h110;
  localparam logic [ADDR_W-1:0] A_RES  = 12'h120;

  localparam int unsigned START_BIT  = 4;
  localparam int unsigned SINGLE_BIT = 5;
  localparam int unsigned CHAN_W     = 4;

  localparam logic [15:0] PDLY_RST = 16'h0020;
  localparam logic [15:0] SWIN_RST = 16'h000C;

  typedef enum logic [1:0] {PH_IDLE, PH_PWR, PH_SMP, PH_SAR} phase_e;

  // bits enabled by the upper half take the new value, the rest keep theirs
  function automatic logic [15:0] mask_merge(input logic [15:0] cur,
                                             input logic [31:0] wd);
    return (cur & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
  endfunction

  // a phase of length lim ends on count lim-1; lim of zero behaves as one
  function automatic logic phase_last(input logic [15:0] cnt,
                                      input logic [15:0] lim);
    return cnt == ((lim == 16'd0) ? 16'd0 : lim - 16'd1);
  endfunction
endpackage

// File: rtl/adc_mask_regs.sv
module adc_mask_regs
  import adc_mask_pkg::*;
#(
  parameter int NCH = 8,
  parameter int RES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              start_ack,
  input  logic              conv_done,
  input  logic [NCH*RES-1:0] rb_flat,
  output logic              conv_wr,
  output logic              ipnd_clr,
  output logic              start_q,
  output logic              single_q,
  output logic [CHAN_W-1:0] chan_q,
  output logic [15:0]       pdly_q,
  output logic [15:0]       swin_q,
  output logic              ien_q,
  output logic              pend_q
);
  localparam int IDX_W = ADDR_W - 2;

  logic [15:0] ctrl_q, ctrl_nxt, merged;

  assign conv_wr  = reg_wr && (reg_addr == A_CONV);
  assign ipnd_clr = reg_wr && (reg_addr == A_IPND) && reg_wdata[0];

  assign start_q  = ctrl_q[START_BIT];
  assign single_q = ctrl_q[SINGLE_BIT];
  assign chan_q   = ctrl_q[CHAN_W-1:0];

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (start_ack) ctrl_nxt[START_BIT] = 1'b0;
    merged = mask_merge(ctrl_nxt, reg_wdata);
    if (busy) merged[START_BIT] = ctrl_nxt[START_BIT];
    if (conv_wr) ctrl_nxt = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pdly_q <= PDLY_RST;
      swin_q <= SWIN_RST;
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nxt;
      if (reg_wr && reg_addr == A_PDLY) pdly_q <= mask_merge(pdly_q, reg_wdata);
      if (reg_wr && reg_addr == A_SWIN) swin_q <= mask_merge(swin_q, reg_wdata);
      if (reg_wr && reg_addr == A_IEN && reg_wdata[16]) ien_q <= reg_wdata[0];
      if (conv_done)     pend_q <= 1'b1;
      else if (ipnd_clr) pend_q <= 1'b0;
    end
  end

  // read path
  logic [ADDR_W-1:0] res_off;
  logic [IDX_W-1:0]  res_idx;
  logic              res_hit;
  logic [RES-1:0]    res_val;

  assign res_off = reg_addr - A_RES;
  assign res_idx = res_off[ADDR_W-1:2];
  assign res_hit = (reg_addr >= A_RES) && (res_off[1:0] == 2'b00) && (int'(res_idx) < NCH);

  always_comb begin
    res_val = '0;
    for (int k = 0; k < NCH; k++)
      if (res_hit && int'(res_idx) == k) res_val = rb_flat[k*RES +: RES];
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CONV:  reg_rdata = {16'h0, ctrl_q};
      A_PDLY:  reg_rdata = {16'h0, pdly_q};
      A_SWIN:  reg_rdata = {16'h0, swin_q};
      A_IEN:   reg_rdata = {31'h0, ien_q};
      A_STAT:  reg_rdata = {31'h0, busy};
      A_IPND:  reg_rdata = {31'h0, pend_q};
      default: reg_rdata = {{(32-RES){1'b0}}, res_val};
    endcase
  end
endmodule

// File: rtl/adc_mask_seq.sv
module adc_mask_seq
  import adc_mask_pkg::*;
#(
  parameter int NCH = 8,
  parameter int RES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_q,
  input  logic              single_q,
  input  logic [CHAN_W-1:0] chan_q,
  input  logic [15:0]       pdly_q,
  input  logic [15:0]       swin_q,
  input  logic              cmp_in,
  output logic              start_ack,
  output logic              launch,
  output logic              busy,
  output logic              in_sar,
  output logic              sample_hold,
  output logic [$clog2(RES)-1:0] bit_idx,
  output logic [RES-1:0]    dac_code,
  output logic              conv_done,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] done_chan,
  output logic [RES-1:0]    done_data
);
  localparam int BIT_W = $clog2(RES);
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

  phase_e           ph_q;
  logic [15:0]      cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic [RES-1:0]   sar_q, trial, keep;
  logic [SEL_W-1:0] chan_lat;
  logic             chan_ok;

  function automatic logic [RES-1:0] trial_of(input logic [RES-1:0] acc,
                                              input logic [BIT_W-1:0] idx);
    return acc | (RES'(1) << idx);
  endfunction

  assign chan_ok     = int'(chan_q) < NCH;
  assign start_ack   = (ph_q == PH_IDLE) && start_q;
  assign launch      = start_ack && single_q && chan_ok;
  assign busy        = ph_q != PH_IDLE;
  assign in_sar      = ph_q == PH_SAR;
  assign sample_hold = ph_q == PH_SMP;
  assign bit_idx     = bit_q;
  assign trial       = trial_of(sar_q, bit_q);
  assign keep        = cmp_in ? trial : sar_q;
  assign dac_code    = in_sar ? trial : '0;
  assign conv_done   = in_sar && (bit_q == '0);
  assign done_chan   = chan_lat;
  assign done_data   = keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      bit_q    <= '0;
      sar_q    <= '0;
      chan_lat <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (launch) begin
          ph_q     <= PH_PWR;
          cnt_q    <= '0;
          chan_lat <= chan_q[SEL_W-1:0];
        end
        PH_PWR: if (phase_last(cnt_q, pdly_q)) begin
          ph_q  <= PH_SMP;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 16'd1;
        PH_SMP: if (phase_last(cnt_q, swin_q)) begin
          ph_q  <= PH_SAR;
          cnt_q <= '0;
          bit_q <= BIT_W'(RES - 1);
          sar_q <= '0;
        end else cnt_q <= cnt_q + 16'd1;
        PH_SAR: begin
          sar_q <= keep;
          if (bit_q == '0) ph_q <= PH_IDLE;
          else bit_q <= bit_q - 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_mask_bank.sv
module adc_mask_bank #(
  parameter int NCH = 8,
  parameter int RES = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conv_done,
  input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] done_chan,
  input  logic [RES-1:0]       done_data,
  output logic [NCH*RES-1:0]   rb_flat
);
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    logic [RES-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else if (conv_done && done_chan == SEL_W'(g)) slot_q <= done_data;
    end
    assign rb_flat[g*RES +: RES] = slot_q;
  end
endmodule

// File: rtl/adc_mask_ctrl.sv
module adc_mask_ctrl
  import adc_mask_pkg::*;
#(
  parameter int NCH = 8,
  parameter int RES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cmp_in,
  output logic [RES-1:0]    dac_code,
  output logic              afe_pwr,
  output logic              sample_hold,
  output logic              irq
);
  localparam int BIT_W = $clog2(RES);
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic              busy, start_ack, launch, in_sar, conv_done;
  logic              conv_wr, ipnd_clr;
  logic              start_q, single_q, ien_q, pend_q;
  logic [CHAN_W-1:0] chan_q;
  logic [15:0]       pdly_q, swin_q;
  logic [BIT_W-1:0]  bit_idx;
  logic [SEL_W-1:0]  done_chan;
  logic [RES-1:0]    done_data;
  logic [NCH*RES-1:0] rb_flat;

  adc_mask_regs #(.NCH(NCH), .RES(RES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .start_ack(start_ack), .conv_done(conv_done), .rb_flat(rb_flat),
    .conv_wr(conv_wr), .ipnd_clr(ipnd_clr), .start_q(start_q),
    .single_q(single_q), .chan_q(chan_q), .pdly_q(pdly_q), .swin_q(swin_q),
    .ien_q(ien_q), .pend_q(pend_q)
  );

  adc_mask_seq #(.NCH(NCH), .RES(RES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_q(start_q), .single_q(single_q),
    .chan_q(chan_q), .pdly_q(pdly_q), .swin_q(swin_q), .cmp_in(cmp_in),
    .start_ack(start_ack), .launch(launch), .busy(busy), .in_sar(in_sar),
    .sample_hold(sample_hold), .bit_idx(bit_idx), .dac_code(dac_code),
    .conv_done(conv_done), .done_chan(done_chan), .done_data(done_data)
  );

  adc_mask_bank #(.NCH(NCH), .RES(RES)) u_bank (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .done_chan(done_chan),
    .done_data(done_data), .rb_flat(rb_flat)
  );

  assign afe_pwr = busy;
  assign irq     = pend_q & ien_q;
endmodule

// File: rtl/adc_mask_ctrl_chk.sv
module adc_mask_ctrl_chk #(
  parameter int NCH = 8,
  parameter int RES = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               start_ack,
  input logic               conv_wr,
  input logic               start_q,
  input logic               single_q,
  input logic [3:0]         chan_q,
  input logic               in_sar,
  input logic [$clog2(RES)-1:0] bit_idx,
  input logic               conv_done,
  input logic               pend_q,
  input logic               ipnd_clr,
  input logic               sample_hold,
  input logic [NCH*RES-1:0] rb_flat
);
  // R5
  sar_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sar && bit_idx != '0) |=> (in_sar && bit_idx == $past(bit_idx) - 1'b1));

  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(rb_flat));

  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> pend_q);

  // R10
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ipnd_clr && !conv_done) |=> !pend_q);

  // R7
  legal_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_q && single_q && (int'(chan_q) < NCH)));

  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ack && !conv_wr) |=> !start_q);

  // R4
  hold_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hold |-> busy);
endmodule

bind adc_mask_ctrl adc_mask_ctrl_chk #(.NCH(NCH), .RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start_ack(start_ack),
  .conv_wr(conv_wr), .start_q(start_q), .single_q(single_q), .chan_q(chan_q),
  .in_sar(in_sar), .bit_idx(bit_idx), .conv_done(conv_done), .pend_q(pend_q),
  .ipnd_clr(ipnd_clr), .sample_hold(sample_hold), .rb_flat(rb_flat)
);

// File: tb/test_adc_mask_ctrl.sv
module test_adc_mask_ctrl;
  localparam int CLK_P = 10;
  localparam int NCH = 8;
  localparam int RES = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmp_in;
  logic [RES-1:0] dac_code;
  logic        afe_pwr, sample_hold, irq;
  logic [RES-1:0] ana_now = '0;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  // ideal comparator: input at or above the trial code
  assign cmp_in = (dac_code <= ana_now);

  adc_mask_ctrl #(.NCH(NCH), .RES(RES)) i_adc_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_in(cmp_in),
    .dac_code(dac_code), .afe_pwr(afe_pwr), .sample_hold(sample_hold), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [11:0] res_addr(input int ch);
    return 12'h120 + 12'(4 * ch);
  endfunction

  // starts a conversion and counts busy and sample cycles until idle
  task automatic convert(input int ch, input logic [RES-1:0] val,
                         output int bcyc, output int scyc);
    logic [31:0] d;
    ana_now = val; bcyc = 0; scyc = 0;
    wr(12'h000, 32'h003F_0030 | 32'(ch));
    @(posedge clk); @(negedge clk);
    rd(12'h10C, d); check("R4 status busy", d, 32'h1);
    rd(12'h000, d); check("R3 start reads back 0", {31'h0, d[4]}, 32'h0);
    while (afe_pwr && bcyc < 5000) begin
      bcyc++;
      if (sample_hold) scyc++;
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h004, d); check("R2 pdly reset", d, 32'h20);
    rd(12'h00C, d); check("R2 swin reset", d, 32'h0C);
    rd(12'h104, d); check("R2 ien reset", d, 32'h0);
    rd(12'h110, d); check("R2 pend reset", d, 32'h0);
    rd(12'h10C, d); check("R2 busy reset", d, 32'h0);
    rd(res_addr(4), d); check("R2 result reset", d, 32'h0);
    check("R2 irq reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(12'h004, 32'h00F0_FFFF);
    rd(12'h004, d); check("R1 partial mask", d, 32'h00F0);
    wr(12'h004, 32'h0000_1234);
    rd(12'h004, d); check("R1 empty mask", d, 32'h00F0);
    wr(12'h004, 32'hFFFF_0003);
    rd(12'h004, d); check("R1 full mask", d, 32'h0003);
    wr(12'h00C, 32'hFFFF_0002);
    rd(12'h00C, d); check("R1 swin write", d, 32'h0002);
  endtask

  task automatic t_timing;
    int b, s;
    logic [31:0] d;
    convert(1, 12'hABC, b, s);
    check("R4 busy cycles 3+2+12", 32'(b), 32'd17);
    check("R4 sample cycles", 32'(s), 32'd2);
    rd(res_addr(1), d); check("R5 result ch1", d, 32'hABC);
    rd(12'h110, d); check("R9 pending after done", d, 32'h1);
    check("R9 irq masked by enable", {31'h0, irq}, 32'h0);
    wr(12'h104, 32'h0001_0001);
    check("R9 irq when enabled", {31'h0, irq}, 32'h1);
    wr(12'h110, 32'h0000_0000);
    check("R10 write 0 keeps pending", {31'h0, irq}, 32'h1);
    wr(12'h110, 32'h0000_0001);
    rd(12'h110, d); check("R10 cleared", d, 32'h0);
    check("R10 irq low", {31'h0, irq}, 32'h0);
    wr(12'h004, 32'hFFFF_0000);
    wr(12'h00C, 32'hFFFF_0001);
    convert(0, 12'hFFF, b, s);
    check("R4 zero delay counts as one", 32'(b), 32'd14);
    rd(res_addr(0), d); check("R5 full scale", d, 32'hFFF);
  endtask

  task automatic t_bank;
    int b, s;
    logic [31:0] d;
    convert(7, 12'h000, b, s);
    rd(res_addr(7), d); check("R5 zero code", d, 32'h0);
    convert(5, 12'h5A5, b, s);
    rd(res_addr(5), d); check("R6 ch5 written", d, 32'h5A5);
    rd(res_addr(1), d); check("R6 ch1 kept", d, 32'hABC);
    rd(res_addr(0), d); check("R6 ch0 kept", d, 32'hFFF);
    rd(res_addr(3), d); check("R6 ch3 untouched", d, 32'h0);
    wr(12'h110, 32'h1);
  endtask

  task automatic t_bad_chan;
    logic [31:0] d;
    wr(12'h000, 32'h003F_0039);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    check("R7 no conversion", {31'h0, afe_pwr}, 32'h0);
    rd(12'h110, d); check("R7 no pending", d, 32'h0);
    rd(12'h000, d); check("R7 start cleared", {31'h0, d[4]}, 32'h0);
    rd(res_addr(1), d); check("R7 ch1 kept", d, 32'hABC);
  endtask

  task automatic t_no_single;
    logic [31:0] d;
    wr(12'h000, 32'h003F_0012);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    check("R8 no conversion", {31'h0, afe_pwr}, 32'h0);
    rd(12'h110, d); check("R8 no pending", d, 32'h0);
    rd(res_addr(2), d); check("R8 ch2 untouched", d, 32'h0);
  endtask

  task automatic t_busy_start;
    logic [31:0] d;
    int n;
    ana_now = 12'h321;
    wr(12'h000, 32'h003F_0032);
    @(posedge clk); @(negedge clk);
    wr(12'h000, 32'h003F_0033);
    n = 0;
    while (afe_pwr && n < 5000) begin n++; @(posedge clk); @(negedge clk); end
    repeat (4) begin @(posedge clk); @(negedge clk); end
    check("R11 no second conversion", {31'h0, afe_pwr}, 32'h0);
    rd(res_addr(2), d); check("R11 first channel result", d, 32'h321);
    rd(res_addr(3), d); check("R11 ch3 untouched", d, 32'h0);
    rd(12'h000, d); check("R11 start not latched", {31'h0, d[4]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mask;
    t_timing;
    t_bank;
    t_bad_chan;
    t_no_single;
    t_busy_start;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule